// File: doc/BRIEF.md
# Network Controller Command and Status Unit

This block sits between a host's command port and the protocol engine of a token-passing network controller. The host writes 8-bit command bytes. The unit decodes each byte into control actions: it enables or disables the transmitter and the receiver, picks the buffer pages used for transmit and receive, sets the broadcast-accept option and the long-packet option, and clears selected status flags.

The unit also keeps the readable status byte. The protocol engine reports its events (transmission finished, acknowledge received, network reconfigured) as single-cycle pulses, and each pulse sets its flag. An active-low interrupt is driven low whenever a flag is set and its bit in a host-written mask is also set.

The transmit-done event also raises an internal pending bit. That bit keeps the transmit interrupt asserted until the host writes the clear-transmit-interrupt command.

Top module: `cmdstat_unit`

## Requirements
- R1: After reset, statusOut is 0x91, intN is 1, the interrupt mask is 0, and txEnable, rxEnable, txPage, rxPage, bcastAccept and longPkt are all 0.
- R2: statusOut bit layout:
  - bit 7 is receiver inhibited, equal to NOT rxEnable.
  - bit 4 is the power-on flag.
  - bit 2 is the reconfiguration flag.
  - bit 1 is transmit acknowledged.
  - bit 0 is transmitter available.
  - bits 6, 5 and 3 read 0.
- R3: Command 0x01 clears txEnable and sets transmitter available. Command 0x02 clears rxEnable. Neither command changes the page registers.
- R4: A command matching b0pp_p100 sets rxEnable. It loads rxPage from bits 5:3 and loads bcastAccept from bit 7.
- R5: A command matching 00pp_p011 sets txEnable and loads txPage from bits 5:3. It also clears the transmitter-available flag and the transmit-acknowledged flag.
- R6: A command matching 0000_c101 loads longPkt from bit 3.
- R7: A command matching 000r_q110 clears the reconfiguration flag when r (bit 4) is 1 and clears the power-on flag when q (bit 3) is 1. With both bits 0 it changes nothing.
- R8: Each event pulse sets its flag, visible one cycle later:
  - txDonePulse sets transmitter available.
  - ackPulse sets transmit acknowledged.
  - reconPulse sets reconfiguration.
- R9: txDonePulse also sets a transmit-interrupt pending bit. Only command 0x00 clears that bit; an enable-transmit command does not.
- R10: maskWe loads the 8-bit mask from maskData. intN is 0 exactly when some mask bit i is 1 and its source i is set. Sources 7 to 1 are statusOut bits 7 to 1; source 0 is the pending bit of R9.
- R11: If an event pulse arrives in the same cycle as a command that clears the same flag, the flag ends up set.
- R12: Command bytes that match no pattern above, and any byte presented while cmdValid is 0, leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte |
| maskWe | input | 1 | Interrupt mask write strobe |
| maskData | input | 8 | New interrupt mask value |
| txDonePulse | input | 1 | Transmission finished event |
| ackPulse | input | 1 | Acknowledge received event |
| reconPulse | input | 1 | Network reconfiguration event |
| statusOut | output | 8 | Status byte |
| intN | output | 1 | Active-low interrupt |
| txEnable | output | 1 | Transmitter enabled |
| txPage | output | 3 | Transmit buffer page |
| rxEnable | output | 1 | Receiver enabled |
| rxPage | output | 3 | Receive buffer page |
| bcastAccept | output | 1 | Accept broadcast packets |
| longPkt | output | 1 | Long packets allowed |

## Verification
An event pulse and a host command that clears the same flag can land on the same clock edge. The bench provokes this three ways, each in a single cycle:
- a reconfiguration pulse together with the flag-clear command,
- an acknowledge pulse together with the enable-transmit command,
- a transmit-done pulse together with the clear-transmit-interrupt command.

In each case the status byte and intN are judged one cycle later, and the flag must still be set. Afterwards a lone clear command must remove the flag, which shows the clear path itself works.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;
  localparam int CMD_W  = 8;
  localparam int PAGE_W = 3;
  localparam int STAT_W = 8;
  localparam int PAGE_LSB = 3;

  // status bit positions (read by host software)
  localparam int ST_RXINH = 7;
  localparam int ST_POR   = 4;
  localparam int ST_RECON = 2;
  localparam int ST_TMA   = 1;
  localparam int ST_TA    = 0;

  typedef struct packed {
    logic              clrTxInt;
    logic              disTx;
    logic              disRx;
    logic              enRx;
    logic              enTx;
    logic              defCfg;
    logic              clrFlags;
    logic              bcastBit;
    logic              longBit;
    logic              clrRecon;
    logic              clrPor;
    logic [PAGE_W-1:0] page;
  } cmdStrobe_t;
endpackage

// File: rtl/cmdstat_decode.sv
module cmdstat_decode
  import cmdstat_pkg::*;
(
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  output cmdStrobe_t       strobe
);
  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      casez (cmdByte)
        8'b0000_0000: strobe.clrTxInt = 1'b1;
        8'b0000_0001: strobe.disTx    = 1'b1;
        8'b0000_0010: strobe.disRx    = 1'b1;
        8'b?0??_?100: begin
          strobe.enRx     = 1'b1;
          strobe.page     = cmdByte[PAGE_LSB +: PAGE_W];
          strobe.bcastBit = cmdByte[7];
        end
        8'b00??_?011: begin
          strobe.enTx = 1'b1;
          strobe.page = cmdByte[PAGE_LSB +: PAGE_W];
        end
        8'b0000_?101: begin
          strobe.defCfg  = 1'b1;
          strobe.longBit = cmdByte[3];
        end
        8'b000?_?110: begin
          strobe.clrFlags = 1'b1;
          strobe.clrRecon = cmdByte[4];
          strobe.clrPor   = cmdByte[3];
        end
        default: strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmdstat_regs.sv
module cmdstat_regs
  import cmdstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic              maskWe,
  input  logic [STAT_W-1:0] maskData,
  input  logic              txDonePulse,
  input  logic              ackPulse,
  input  logic              reconPulse,
  output logic [STAT_W-1:0] statusOut,
  output logic              intN,
  output logic              txEnable,
  output logic [PAGE_W-1:0] txPage,
  output logic              rxEnable,
  output logic [PAGE_W-1:0] rxPage,
  output logic              bcastAccept,
  output logic              longPkt
);
  logic porFlag, reconFlag, tmaFlag, taFlag, txPend;
  logic [STAT_W-1:0] intMask;
  logic [STAT_W-1:0] intSrc;
  logic [STAT_W-1:0] intHit;

  // mode and page state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnable    <= 1'b0;
      txPage      <= '0;
      rxEnable    <= 1'b0;
      rxPage      <= '0;
      bcastAccept <= 1'b0;
      longPkt     <= 1'b0;
      intMask     <= '0;
    end else begin
      if (strobe.enTx) begin
        txEnable <= 1'b1;
        txPage   <= strobe.page;
      end
      if (strobe.disTx) txEnable <= 1'b0;
      if (strobe.enRx) begin
        rxEnable    <= 1'b1;
        rxPage      <= strobe.page;
        bcastAccept <= strobe.bcastBit;
      end
      if (strobe.disRx)  rxEnable <= 1'b0;
      if (strobe.defCfg) longPkt  <= strobe.longBit;
      if (maskWe)        intMask  <= maskData;
    end
  end

  // flags: clear first, set last so an event is never lost
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porFlag   <= 1'b1;
      reconFlag <= 1'b0;
      tmaFlag   <= 1'b0;
      taFlag    <= 1'b1;
      txPend    <= 1'b0;
    end else begin
      if (strobe.clrFlags && strobe.clrPor)   porFlag   <= 1'b0;
      if (strobe.clrFlags && strobe.clrRecon) reconFlag <= 1'b0;
      if (reconPulse)                         reconFlag <= 1'b1;
      if (strobe.enTx)                        tmaFlag   <= 1'b0;
      if (ackPulse)                           tmaFlag   <= 1'b1;
      if (strobe.enTx)                        taFlag    <= 1'b0;
      if (strobe.disTx || txDonePulse)        taFlag    <= 1'b1;
      if (strobe.clrTxInt)                    txPend    <= 1'b0;
      if (txDonePulse)                        txPend    <= 1'b1;
    end
  end

  always_comb begin
    statusOut           = '0;
    statusOut[ST_RXINH] = ~rxEnable;
    statusOut[ST_POR]   = porFlag;
    statusOut[ST_RECON] = reconFlag;
    statusOut[ST_TMA]   = tmaFlag;
    statusOut[ST_TA]    = taFlag;
    intSrc              = statusOut;
    intSrc[ST_TA]       = txPend;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_hit
    assign intHit[i] = intMask[i] & intSrc[i];
  end

  assign intN = ~|intHit;
endmodule

// File: rtl/cmdstat_unit.sv
module cmdstat_unit
  import cmdstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdByte,
  input  logic              maskWe,
  input  logic [STAT_W-1:0] maskData,
  input  logic              txDonePulse,
  input  logic              ackPulse,
  input  logic              reconPulse,
  output logic [STAT_W-1:0] statusOut,
  output logic              intN,
  output logic              txEnable,
  output logic [PAGE_W-1:0] txPage,
  output logic              rxEnable,
  output logic [PAGE_W-1:0] rxPage,
  output logic              bcastAccept,
  output logic              longPkt
);
  cmdStrobe_t strobe;

  cmdstat_decode i_decode (
    .cmdValid (cmdValid),
    .cmdByte  (cmdByte),
    .strobe   (strobe)
  );

  cmdstat_regs i_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .maskWe      (maskWe),
    .maskData    (maskData),
    .txDonePulse (txDonePulse),
    .ackPulse    (ackPulse),
    .reconPulse  (reconPulse),
    .statusOut   (statusOut),
    .intN        (intN),
    .txEnable    (txEnable),
    .txPage      (txPage),
    .rxEnable    (rxEnable),
    .rxPage      (rxPage),
    .bcastAccept (bcastAccept),
    .longPkt     (longPkt)
  );
endmodule

// File: rtl/cmdstat_check.sv
module cmdstat_check
  import cmdstat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [CMD_W-1:0]  cmdByte,
  input logic              maskWe,
  input logic              txDonePulse,
  input logic              ackPulse,
  input logic              reconPulse,
  input logic [STAT_W-1:0] statusOut,
  input logic              intN,
  input logic              txEnable,
  input logic [PAGE_W-1:0] rxPage,
  input logic              rxEnable,
  input logic              bcastAccept
);
  a_r8_done_sets_ta: assert property (@(posedge clk) disable iff (!rstN)
    txDonePulse |=> statusOut[ST_TA]);

  a_r8_ack_sets_tma: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> statusOut[ST_TMA]);

  a_r11_recon_wins: assert property (@(posedge clk) disable iff (!rstN)
    reconPulse |=> statusOut[ST_RECON]);

  a_r3_dis_tx: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdByte == 8'h01) |=> (!txEnable && statusOut[ST_TA]));

  a_r4_rx_page: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdByte[6] && cmdByte[2:0] == 3'b100) |=>
      (rxEnable && rxPage == $past(cmdByte[5:3]) && bcastAccept == $past(cmdByte[7])));

  a_r5_tx_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdByte[7:6] == 2'b00 && cmdByte[2:0] == 3'b011 && !txDonePulse && !ackPulse)
      |=> (txEnable && !statusOut[ST_TA] && !statusOut[ST_TMA]));

  a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !maskWe && !txDonePulse && !ackPulse && !reconPulse) |=>
      ($stable(statusOut) && $stable(intN) && $stable(txEnable) && $stable(rxEnable)));
endmodule

bind cmdstat_unit cmdstat_check i_check (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdByte     (cmdByte),
  .maskWe      (maskWe),
  .txDonePulse (txDonePulse),
  .ackPulse    (ackPulse),
  .reconPulse  (reconPulse),
  .statusOut   (statusOut),
  .intN        (intN),
  .txEnable    (txEnable),
  .rxPage      (rxPage),
  .rxEnable    (rxEnable),
  .bcastAccept (bcastAccept)
);

// File: tb/test_cmdstat_unit.sv
module test_cmdstat_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdByte = '0;
  logic       maskWe = 1'b0;
  logic [7:0] maskData = '0;
  logic       txDonePulse = 1'b0;
  logic       ackPulse = 1'b0;
  logic       reconPulse = 1'b0;
  logic [7:0] statusOut;
  logic       intN, txEnable, rxEnable, bcastAccept, longPkt;
  logic [2:0] txPage, rxPage;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cmdstat_unit i_cmdstat_unit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .maskWe(maskWe), .maskData(maskData), .txDonePulse(txDonePulse),
    .ackPulse(ackPulse), .reconPulse(reconPulse), .statusOut(statusOut),
    .intN(intN), .txEnable(txEnable), .txPage(txPage), .rxEnable(rxEnable),
    .rxPage(rxPage), .bcastAccept(bcastAccept), .longPkt(longPkt)
  );

  // {cmd, status, txEn, txPage, rxEn, rxPage, bcast, long}
  localparam logic [25:0] VEC [12] = '{
    {8'h2C, 8'h11, 1'b0, 3'd0, 1'b1, 3'd5, 1'b0, 1'b0},  // R4
    {8'hA4, 8'h11, 1'b0, 3'd0, 1'b1, 3'd4, 1'b1, 1'b0},  // R4 broadcast
    {8'h1B, 8'h10, 1'b1, 3'd3, 1'b1, 3'd4, 1'b1, 1'b0},  // R5
    {8'h0D, 8'h10, 1'b1, 3'd3, 1'b1, 3'd4, 1'b1, 1'b1},  // R6
    {8'h05, 8'h10, 1'b1, 3'd3, 1'b1, 3'd4, 1'b1, 1'b0},  // R6
    {8'h0E, 8'h00, 1'b1, 3'd3, 1'b1, 3'd4, 1'b1, 1'b0},  // R7
    {8'h07, 8'h00, 1'b1, 3'd3, 1'b1, 3'd4, 1'b1, 1'b0},  // R12
    {8'h01, 8'h01, 1'b0, 3'd3, 1'b1, 3'd4, 1'b1, 1'b0},  // R3
    {8'h02, 8'h81, 1'b0, 3'd3, 1'b0, 3'd4, 1'b1, 1'b0},  // R3 R2
    {8'hC4, 8'h81, 1'b0, 3'd3, 1'b0, 3'd4, 1'b1, 1'b0},  // R12
    {8'h53, 8'h81, 1'b0, 3'd3, 1'b0, 3'd4, 1'b1, 1'b0},  // R12
    {8'h33, 8'h80, 1'b1, 3'd6, 1'b0, 3'd4, 1'b1, 1'b0}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] c, input logic td,
                      input logic ak, input logic rc, input logic mw, input logic [7:0] md);
    cmdValid = v; cmdByte = c; txDonePulse = td; ackPulse = ak;
    reconPulse = rc; maskWe = mw; maskData = md;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdByte = '0; txDonePulse = 1'b0; ackPulse = 1'b0;
    reconPulse = 1'b0; maskWe = 1'b0; maskData = '0;
  endtask

  task automatic checkReset();
    check("R1 status", statusOut, 8'h91);
    check("R1 intN", intN, 1'b1);
    check("R1 enables", {txEnable, rxEnable, bcastAccept, longPkt}, 4'h0);
    check("R1 pages", {txPage, rxPage}, 6'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();

    for (int i = 0; i < 12; i++) begin
      step(1'b1, VEC[i][25:18], 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R2 R3 R4 R5 R6 R7 R12 status", statusOut, VEC[i][17:10]);
      check("R3 R5 tx", {txEnable, txPage}, VEC[i][9:6]);
      check("R3 R4 rx", {rxEnable, rxPage, bcastAccept}, VEC[i][5:1]);
      check("R6 long", longPkt, VEC[i][0]);
      check("R10 intN masked off", intN, 1'b1);
    end

    // R9 R10 transmit pending interrupt
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
    check("R10 mask0 no pending", intN, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R8 done sets TA", statusOut, 8'h81);
    check("R9 pending int", intN, 1'b0);
    step(1'b1, 8'h1B, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R5 TA cleared", statusOut, 8'h80);
    check("R9 enTx keeps pending", intN, 1'b0);
    step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R9 clear tx int", intN, 1'b1);

    // R8 R10 ack and reconfiguration
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h06);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R8 ack", statusOut, 8'h82);
    check("R10 ack int", intN, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R8 recon", statusOut, 8'h86);
    step(1'b1, 8'h16, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R7 clear recon", statusOut, 8'h82);
    check("R10 still low", intN, 1'b0);
    step(1'b1, 8'h1B, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R5 TMA cleared", statusOut, 8'h80);
    check("R10 released", intN, 1'b1);

    // R11 same-cycle collisions
    step(1'b1, 8'h16, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R11 recon beats clear", statusOut, 8'h84);
    step(1'b1, 8'h16, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R11 lone clear", statusOut, 8'h80);
    step(1'b1, 8'h1B, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R11 ack beats enTx", statusOut, 8'h82);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
    step(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R11 done status", statusOut, 8'h83);
    check("R11 done beats clear", intN, 1'b0);
    step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R11 lone clear int", intN, 1'b1);

    // R12 byte without valid
    step(1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R12 no valid tx", txEnable, 1'b1);
    check("R12 no valid status", statusOut, 8'h83);

    // R2 R10 receiver inhibited as a source
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80);
    check("R10 rx inhibit int", intN, 1'b0);
    step(1'b1, 8'hA4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R2 rx enabled", statusOut, 8'h03);
    check("R10 rx inhibit gone", intN, 1'b1);

    // R1 reset again
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();

    // R7 selective clears
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R8 recon after reset", statusOut, 8'h95);
    step(1'b1, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R7 no selectors", statusOut, 8'h95);
    step(1'b1, 8'h0E, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R7 clear por", statusOut, 8'h85);
    step(1'b1, 8'h16, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R7 clear recon", statusOut, 8'h81);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule